// File: doc/BRIEF.md
# Selectable Ratio Clock Output Divider

This block turns the reference clock into one divided clock for up to two output pins. Each pin has a 6-bit select code held in the block. A code in the divider range picks one of sixteen ratios from 1 to 192. The set includes the non-integer ratio 1.5, which is built from both edges of the reference clock. Software can rewrite a code at any time through a one-cycle write strobe. The new ratio is taken up at the next period boundary of the running output, so the pin never shows a shortened pulse.

There is only one divider. When both pins ask for it, pin 0 keeps it. Pin 1 then drives a constant 0 and a conflict flag is raised. A pin whose code lies below the divider range also drives 0, and its valid flag stays low. After reset, pin 0 holds the slowest ratio, so a host can run from it straight away. Pin 1 holds a code outside the divider range.

Top module: `clkdiv_out`

## Requirements
- R1: Select codes 0x30 through 0x3F give output periods of 1, 1.5, 2, 3, 4, 6, 8, 12, 16, 24, 32, 48, 64, 96, 128 and 192 reference cycles, in that order of code.
- R2: At code 0x31 (ratio 1.5) the output is high for two reference half-periods and low for one, repeating.
- R3: At every even integer ratio N the output is high for exactly N/2 reference cycles and low for N/2.
- R4: At ratio 3 (code 0x33) the output is high for three reference half-periods and low for three, using both edges.
- R5: After reset, pin 0 has code 0x3F (ratio 192) and owns the divider with its valid flag high, and pin 1 has code 0x00.
- R6: When both codes are 0x30 or above, pin 0 outputs the divided clock, pin 1 outputs 0 with its valid flag low, and the conflict flag is 1.
- R7: When only pin 1 has a code of 0x30 or above, pin 1 outputs the divided clock with its valid flag high, and the conflict flag is 0.
- R8: A new code, or a change of owner, takes effect only at the start of an output period. The period in progress completes at its old ratio and no shortened high pulse appears.
- R9: A pin whose code is below 0x30 outputs constant 0 and has its valid flag low. When neither pin requests, neither outputs a clock.
- R10: Synchronous reset (active high) returns the period position to zero, clears both outputs and flags, and restores both default codes, discarding earlier writes.
- R11: At ratio 1 (code 0x30) the output repeats the reference clock waveform.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock. Both edges are used. |
| rst | input | 1 | Synchronous reset, active high |
| sel_wr | input | 2 | Write strobe per pin for the select code, one cycle |
| sel_wdata | input | 6 | Select code written to each pin whose strobe is high |
| pin_clk | output | 2 | Clock output per pin, 0 when the pin does not own the divider |
| pin_valid | output | 2 | High while the pin carries the divided clock |
| pin_conflict | output | 1 | High while both pins request the divider |

## Verification
The hardest case to reach is a ratio change that arrives part way through a period, especially when the divide-by-1.5 pattern starts its period on a falling edge and so cannot yet accept a change. The stimulus walks through every code in turn. Each write lands at whatever phase the previous ratio has reached, and one write is placed deliberately mid-period at the slowest ratio. A half-period reference model is compared against both pins at every clock edge, and the measured high and period lengths are checked for each code.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
  localparam int SEL_W  = 6;
  localparam int HALF_W = 9;

  typedef logic [SEL_W-1:0]  sel_t;
  typedef logic [HALF_W-1:0] half_t;

  // Codes whose two top bits are set request the divider
  function automatic logic wants_divider(input sel_t code);
    return code[SEL_W-1] & code[SEL_W-2];
  endfunction

  // Period length in reference half-periods: odd low bit -> 3*2^k, else 2*2^k
  function automatic half_t half_period(input sel_t code);
    half_t base;
    base = code[0] ? half_t'(3) : half_t'(2);
    return half_t'(base << code[3:1]);
  endfunction

  // High part of a period: the larger half when the length is odd
  function automatic half_t high_halves(input half_t len);
    return half_t'((len + half_t'(1)) >> 1);
  endfunction

  // Advance a slot index by step, wrapping at len
  function automatic half_t next_slot(input half_t pos, input half_t len,
                                      input logic [1:0] step);
    logic [HALF_W:0] s;
    s = {1'b0, pos} + {{(HALF_W-1){1'b0}}, step};
    if (s >= {1'b0, len}) s = s - {1'b0, len};
    return half_t'(s);
  endfunction
endpackage

// File: rtl/clkdiv_sel_regs.sv
`timescale 1ns/1ps
module clkdiv_sel_regs
  import clkdiv_pkg::*;
#(
  parameter int NPIN = 2,
  parameter logic [NPIN*SEL_W-1:0] RESET_CODES = {NPIN*SEL_W{1'b0}}
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NPIN-1:0]         wr,
  input  sel_t                    wdata,
  output logic [NPIN*SEL_W-1:0]   codes
);
  sel_t code_q [NPIN];

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst)        code_q[i] <= RESET_CODES[i*SEL_W +: SEL_W];
      else if (wr[i]) code_q[i] <= wdata;
    end
    assign codes[i*SEL_W +: SEL_W] = code_q[i];
  end
endmodule

// File: rtl/clkdiv_arbiter.sv
`timescale 1ns/1ps
module clkdiv_arbiter
  import clkdiv_pkg::*;
#(
  parameter int NPIN = 2
) (
  input  logic [NPIN*SEL_W-1:0] codes,
  output logic [NPIN-1:0]       grant,
  output logic                  any_grant,
  output logic                  conflict,
  output sel_t                  win_code
);
  logic [NPIN-1:0] req;

  always_comb begin
    logic taken;
    taken    = 1'b0;
    grant    = '0;
    win_code = '0;
    for (int i = 0; i < NPIN; i++) begin
      req[i] = wants_divider(codes[i*SEL_W +: SEL_W]);
      if (req[i] && !taken) begin
        grant[i] = 1'b1;
        win_code = codes[i*SEL_W +: SEL_W];
        taken    = 1'b1;
      end
    end
    any_grant = taken;
    conflict  = (req & (req - 1'b1)) != '0;
  end
endmodule

// File: rtl/clkdiv_halfgen.sv
`timescale 1ns/1ps
module clkdiv_halfgen
  import clkdiv_pkg::*;
#(
  parameter int    NPIN         = 2,
  parameter half_t RESET_HALVES = half_t'(384)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] grant_in,
  input  logic            any_grant,
  input  sel_t            win_code,
  input  logic            conflict_in,
  output logic            adopt,
  output half_t           hc,
  output half_t           h_act,
  output logic [NPIN-1:0] grant_q,
  output logic            conflict_q,
  output logic [NPIN-1:0] hi_q,
  output logic [NPIN-1:0] lo_next
);
  half_t           h_use, hi_cnt, slot_b, hc_nx;
  logic [NPIN-1:0] g_use;
  logic            val_a, val_b;

  // A period starts when the first slot of a pair is slot zero
  assign adopt = (hc == '0);

  always_comb begin
    h_use  = (adopt && any_grant) ? half_period(win_code) : h_act;
    g_use  = adopt ? grant_in : grant_q;
    hi_cnt = high_halves(h_use);
    slot_b = next_slot(hc, h_use, 2'd1);
    hc_nx  = next_slot(hc, h_use, 2'd2);
    val_a  = hc < hi_cnt;
    val_b  = slot_b < hi_cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hc         <= '0;
      h_act      <= RESET_HALVES;
      grant_q    <= '0;
      conflict_q <= 1'b0;
      hi_q       <= '0;
      lo_next    <= '0;
    end else begin
      hc      <= hc_nx;
      h_act   <= h_use;
      grant_q <= g_use;
      if (adopt) conflict_q <= conflict_in;
      hi_q    <= {NPIN{val_a}} & g_use;
      lo_next <= {NPIN{val_b}} & g_use;
    end
  end
endmodule

// File: rtl/clkdiv_edge_merge.sv
`timescale 1ns/1ps
module clkdiv_edge_merge #(
  parameter int NPIN = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] hi_q,
  input  logic [NPIN-1:0] lo_next,
  output logic [NPIN-1:0] pin_clk
);
  logic [NPIN-1:0] lo_q;

  always_ff @(negedge clk) begin
    if (rst) lo_q <= '0;
    else     lo_q <= lo_next;
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_mux
    assign pin_clk[i] = clk ? hi_q[i] : lo_q[i];
  end
endmodule

// File: rtl/clkdiv_out.sv
`timescale 1ns/1ps
module clkdiv_out
  import clkdiv_pkg::*;
#(
  parameter int NPIN = 2,
  parameter logic [NPIN*SEL_W-1:0] SEL_RESET = {6'h00, 6'h3F},
  localparam half_t RESET_HALVES = half_period(SEL_RESET[SEL_W-1:0])
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] sel_wr,
  input  logic [SEL_W-1:0] sel_wdata,
  output logic [NPIN-1:0] pin_clk,
  output logic [NPIN-1:0] pin_valid,
  output logic            pin_conflict
);
  logic [NPIN*SEL_W-1:0] codes;
  logic [NPIN-1:0]       grant_in, lo_next, hi_q;
  logic                  any_grant, conflict_in, adopt;
  sel_t                  win_code;
  half_t                 hc, h_act;

  clkdiv_sel_regs #(.NPIN(NPIN), .RESET_CODES(SEL_RESET)) u_regs (
    .clk(clk), .rst(rst), .wr(sel_wr), .wdata(sel_wdata), .codes(codes)
  );

  clkdiv_arbiter #(.NPIN(NPIN)) u_arb (
    .codes(codes), .grant(grant_in), .any_grant(any_grant),
    .conflict(conflict_in), .win_code(win_code)
  );

  clkdiv_halfgen #(.NPIN(NPIN), .RESET_HALVES(RESET_HALVES)) u_gen (
    .clk(clk), .rst(rst), .grant_in(grant_in), .any_grant(any_grant),
    .win_code(win_code), .conflict_in(conflict_in), .adopt(adopt),
    .hc(hc), .h_act(h_act), .grant_q(pin_valid), .conflict_q(pin_conflict),
    .hi_q(hi_q), .lo_next(lo_next)
  );

  clkdiv_edge_merge #(.NPIN(NPIN)) u_merge (
    .clk(clk), .rst(rst), .hi_q(hi_q), .lo_next(lo_next), .pin_clk(pin_clk)
  );
endmodule

// File: rtl/clkdiv_out_chk.sv
`timescale 1ns/1ps
module clkdiv_out_chk
  import clkdiv_pkg::*;
#(
  parameter int NPIN = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            adopt,
  input half_t           hc,
  input half_t           h_act,
  input logic [NPIN-1:0] valid,
  input logic            conflict,
  input logic [NPIN-1:0] lo_next
);
  AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (rst)
    $onehot0(valid)); // R6
  AST_CONFLICT_PRIO: assert property (@(posedge clk) disable iff (rst)
    conflict |-> (valid[0] && !valid[1])); // R6
  AST_RATIO_HOLD: assert property (@(posedge clk) disable iff (rst)
    !adopt |=> $stable(h_act)); // R8
  AST_OWNER_HOLD: assert property (@(posedge clk) disable iff (rst)
    !adopt |=> $stable(valid)); // R8
  AST_LOW_AT_SWITCH: assert property (@(posedge clk) disable iff (rst)
    adopt |-> (lo_next == '0)); // R8
  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (rst)
    hc < h_act); // R1
endmodule

bind clkdiv_out clkdiv_out_chk #(.NPIN(NPIN)) u_chk (
  .clk(clk), .rst(rst), .adopt(adopt), .hc(hc), .h_act(h_act),
  .valid(pin_valid), .conflict(pin_conflict), .lo_next(lo_next)
);

// File: tb/clkdiv_out_test.sv
`timescale 1ns/1ps
module clkdiv_out_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] sel_wr = '0;
  logic [5:0] sel_wdata = '0;
  logic [1:0] pin_clk, pin_valid;
  logic       pin_conflict;

  clkdiv_out uut (
    .clk(clk), .rst(rst), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
    .pin_clk(pin_clk), .pin_valid(pin_valid), .pin_conflict(pin_conflict)
  );

  always #4 clk = ~clk;

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R10";

  // reference model state, in half-periods
  int m_pos, m_len, m_sel0, m_sel1;
  bit m_g0, m_g1, m_cf, m_inrst;
  logic [1:0] e_clk;
  // measurement on pin 0
  int hidx = 0, last_rise = 0, meas_per = 0, meas_hi = 0;
  logic p0 = 1'b0;

  function automatic int len_of(input int idx);
    case (idx)
      0: return 2;    1: return 3;    2: return 4;    3: return 6;
      4: return 8;    5: return 12;   6: return 16;   7: return 24;
      8: return 32;   9: return 48;   10: return 64;  11: return 96;
      12: return 128; 13: return 192; 14: return 256; default: return 384;
    endcase
  endfunction

  task automatic check(input string req, input bit ok, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit high_slot(input int pos, input int len);
    return pos < (len - len / 2);
  endfunction

  task automatic model_pos(input logic r, input logic [1:0] we, input logic [5:0] wd);
    bit hv;
    if (r) begin
      m_pos = 0; m_len = 384; m_g0 = 0; m_g1 = 0; m_cf = 0;
      m_sel0 = 63; m_sel1 = 0; m_inrst = 1; e_clk = 2'b00;
      return;
    end
    m_inrst = 0;
    if (m_pos == 0) begin
      m_g0 = (m_sel0 >= 48);
      m_g1 = (m_sel1 >= 48) && !m_g0;
      m_cf = (m_sel0 >= 48) && (m_sel1 >= 48);
      if (m_g0)      m_len = len_of(m_sel0 - 48);
      else if (m_g1) m_len = len_of(m_sel1 - 48);
    end
    hv = high_slot(m_pos, m_len);
    e_clk = {hv && m_g1, hv && m_g0};
    m_pos = (m_pos + 1) % m_len;
    if (we[0]) m_sel0 = wd;
    if (we[1]) m_sel1 = wd;
  endtask

  task automatic model_neg();
    bit hv;
    if (m_inrst) begin e_clk = 2'b00; return; end
    hv = high_slot(m_pos, m_len);
    e_clk = {hv && m_g1, hv && m_g0};
    m_pos = (m_pos + 1) % m_len;
  endtask

  task automatic compare(input bit pos_half);
    check(cur_req, pin_clk === e_clk, pin_clk, e_clk);
    if (pos_half) begin
      check(cur_req, pin_valid === {m_g1, m_g0}, pin_valid, {m_g1, m_g0});
      check(cur_req, pin_conflict === m_cf, pin_conflict, m_cf);
    end
    hidx++;
    if (pin_clk[0] && !p0) begin meas_per = hidx - last_rise; last_rise = hidx; end
    if (!pin_clk[0] && p0) meas_hi = hidx - last_rise;
    p0 = pin_clk[0];
  endtask

  task automatic tick(input logic r, input logic [1:0] we, input logic [5:0] wd);
    rst = r; sel_wr = we; sel_wdata = wd;
    @(posedge clk); #2;
    model_pos(r, we, wd);
    compare(1'b1);
    sel_wr = '0;
    @(negedge clk); #2;
    model_neg();
    compare(1'b0);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 2'b00, 6'h00);
  endtask

  task automatic wr(input int pin, input logic [5:0] code);
    tick(1'b0, (pin == 0) ? 2'b01 : 2'b10, code);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // R10: reset state
    cur_req = "R10";
    for (int i = 0; i < 3; i++) tick(1'b1, 2'b00, 6'h00);
    // R5: default ratio 192 on pin 0
    cur_req = "R5";
    tick(1'b0, 2'b00, 6'h00);
    check("R5", pin_valid === 2'b01, pin_valid, 1);
    run(800);
    check("R5", meas_per == 384, meas_per, 384);
    check("R5", pin_valid[1] === 1'b0, pin_valid[1], 0);

    // R1..R4, R11: sweep every divider code on pin 0
    for (int c = 0; c < 16; c++) begin
      case (c)
        0: cur_req = "R11";
        1: cur_req = "R2";
        3: cur_req = "R4";
        default: cur_req = (c % 2 == 0) ? "R3" : "R1";
      endcase
      wr(0, 6'(48 + c));
      run(600);
      check(cur_req, meas_per == len_of(c), meas_per, len_of(c));
      check(cur_req, meas_hi == len_of(c) - len_of(c) / 2, meas_hi,
            len_of(c) - len_of(c) / 2);
    end

    // R8: change mid-period at the slowest ratio
    cur_req = "R8";
    wr(0, 6'h3F);
    run(450);
    run(100);
    wr(0, 6'h31);
    check("R8", pin_valid === 2'b01, pin_valid, 1);
    run(400);
    check("R8", meas_per == 3, meas_per, 3);

    // R6: both pins request
    cur_req = "R6";
    wr(0, 6'h34);
    wr(1, 6'h32);
    run(40);
    check("R6", pin_conflict === 1'b1, pin_conflict, 1);
    check("R6", pin_valid === 2'b01, pin_valid, 1);

    // R7: pin 0 leaves the divider range, pin 1 takes over
    cur_req = "R7";
    wr(0, 6'h05);
    run(40);
    check("R7", pin_valid === 2'b10, pin_valid, 2);
    check("R7", pin_conflict === 1'b0, pin_conflict, 0);

    // R9: neither pin requests
    cur_req = "R9";
    wr(1, 6'h2F);
    run(40);
    check("R9", pin_valid === 2'b00, pin_valid, 0);
    run(40);

    // R10: reset mid-run restores defaults and discards writes
    cur_req = "R10";
    wr(1, 6'h31);
    run(10);
    tick(1'b1, 2'b00, 6'h00);
    tick(1'b1, 2'b00, 6'h00);
    check("R10", pin_valid === 2'b00, pin_valid, 0);
    check("R10", pin_clk === 2'b00, pin_clk, 0);
    tick(1'b0, 2'b00, 6'h00);
    check("R10", pin_valid === 2'b01, pin_valid, 1);
    check("R10", pin_conflict === 1'b0, pin_conflict, 0);
    run(800);
    check("R10", meas_per == 384, meas_per, 384);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule